// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

This block holds a bank of identical countdown-style event timers behind a plain 32-bit register bus. Each channel has a 28-bit up-counter, a compare/reload value, and its own clock divider. It counts toward the compare value and raises a pending flag when the count gets there. In repeat mode the counter wraps to zero and keeps running, which gives a periodic tick. In one-shot mode the channel turns itself off after one expiry, which gives a single deadline.

Software uses a channel in four steps. It stops the channel by writing zero to control. It clears any stale pending flag, loads a new compare value and zeroes the live count. It then writes control again with the enable bit set, the mode bit, and the divider. Each channel drives a level interrupt line, and that line is high while the channel's pending flag and its interrupt enable are both set. Software acknowledges the interrupt by writing a one to the pending bit.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register of every channel reads zero, every interrupt output is low and the read data bus is zero.
- R2: Channel n occupies the 16 bytes starting at byte address 0x10*n. Word 0x0 holds the compare value, 0x4 the live count, 0x8 control and 0xC the interrupt register. A write takes effect at the clock edge that samples it. Read data appears on the edge that samples the read strobe and holds until the next read. The compare and count registers keep only their low 28 bits.
- R3: In the control word, bit 28 is run enable and bit 24 is the mode (1 = repeat, 0 = one-shot). Bits 15:0 hold the divider. All other control bits, and all interrupt-register bits other than 20 and 16, read as zero.
- R4: With divider field value v, the count advances once every D = max(v,2) clocks. Starting from count 0, the pending flag becomes visible compare*D clocks after the edge that wrote the enable.
- R5: In one-shot mode, the expiry clears the enable bit by itself and the count stays at the compare value.
- R6: In repeat mode, the expiry returns the count to 0 and counting continues with the enable still set. The next expiry comes compare*D clocks after the previous one.
- R7: In the interrupt register, bit 20 is the interrupt enable and bit 16 is the pending flag. Writing 1 to bit 16 clears the flag and writing 0 to it leaves the flag unchanged. If an expiry and a clear fall on the same edge, the flag stays set.
- R8: A channel's interrupt output is high exactly when its pending flag and its interrupt enable are both set. It goes low on the edge after a clearing write.
- R9: Writing zero to control halts the channel at once, and the count then holds its value.
- R10: The count register can be written. Counting resumes from the written value, so expiry comes (compare - count)*D clocks after the enable.
- R11: Writes to channel slots at or beyond the sixth are ignored, and reads from those slots return zero.
- R12: Channels count and interrupt independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 6 | Level interrupt, one per channel |

## Verification
The bench sweeps the divider through 0, 1, 2 and odd values, and counts expiry to the exact cycle. A clamp that lets 0 or 1 through, or a divider that is off by one, shows up as a wrong expiry time. It checks that a one-shot channel drops its enable and holds its count, and that a repeat channel wraps and fires again one period later. Logic that mixed the two modes would leave the enable on, or would fire only once. It also checks the following:
- A write of 0 to the pending bit leaves the flag alone, while a write of 1 clears it and drops the line on the next clock. A design that cleared on any write would lose the interrupt.
- Preloading the count shortens the first period.
- A stopped channel's count stays frozen.
- Accesses to unmapped slots leave every real channel unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned BUS_W        = 32;
   localparam int unsigned CTL_EN_BIT   = 28;
   localparam int unsigned CTL_REP_BIT  = 24;
   localparam int unsigned IRQ_IE_BIT   = 20;
   localparam int unsigned IRQ_PEND_BIT = 16;

   typedef enum logic [1:0] {
      REG_CMP = 2'd0,
      REG_CNT = 2'd1,
      REG_CTL = 2'd2,
      REG_IRQ = 2'd3
   } tmr_reg_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

   logic [DIV_W-1:0] eff_div;
   logic [DIV_W-1:0] acc_q;
   logic             wrap;

   assign eff_div = (div < MIN_DIV) ? MIN_DIV : div;
   assign wrap    = (acc_q >= eff_div - DIV_W'(1));
   assign tick    = run && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc_q <= '0;
      else if (!run)       acc_q <= '0;
      else if (wrap)       acc_q <= '0;
      else                 acc_q <= acc_q + DIV_W'(1);
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cmp,
   input  logic             rep,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic [CNT_W-1:0] nxt;

   assign nxt = cnt + CNT_W'(1);
   assign hit = tick && (nxt == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (tick) begin
         if (hit && rep)    cnt <= '0;
         else               cnt <= nxt;
      end
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 28,
   parameter int unsigned DIV_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [3:0]            wr_sel,
   input  logic [BUS_W-1:0]      wdata,
   output logic [3:0][BUS_W-1:0] regs_o,
   output logic                  irq_o,
   output logic                  en_o,
   output logic                  rep_o,
   output logic                  pend_o,
   output logic                  hit_o,
   output logic [CNT_W-1:0]      cnt_o
);
   logic [CNT_W-1:0] cmp_q;
   logic [DIV_W-1:0] div_q;
   logic             en_q, rep_q, ie_q, pend_q;
   logic             tick;

   tmr_prescaler #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(en_q), .div(div_q), .tick(tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .load(wr_sel[REG_CNT]), .load_val(wdata[CNT_W-1:0]),
      .cmp(cmp_q), .rep(rep_q), .cnt(cnt_o), .hit(hit_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         div_q  <= '0;
         en_q   <= 1'b0;
         rep_q  <= 1'b0;
         ie_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (wr_sel[REG_CMP]) cmp_q <= wdata[CNT_W-1:0];
         if (wr_sel[REG_CTL]) begin
            en_q  <= wdata[CTL_EN_BIT];
            rep_q <= wdata[CTL_REP_BIT];
            div_q <= wdata[DIV_W-1:0];
         end else if (hit_o && !rep_q) begin
            en_q  <= 1'b0;
         end
         if (wr_sel[REG_IRQ]) ie_q <= wdata[IRQ_IE_BIT];
         if (hit_o)                                     pend_q <= 1'b1;
         else if (wr_sel[REG_IRQ] && wdata[IRQ_PEND_BIT]) pend_q <= 1'b0;
      end
   end

   assign regs_o[REG_CMP] = BUS_W'(cmp_q);
   assign regs_o[REG_CNT] = BUS_W'(cnt_o);
   assign regs_o[REG_CTL] = BUS_W'(div_q) | (BUS_W'(rep_q) << CTL_REP_BIT)
                          | (BUS_W'(en_q) << CTL_EN_BIT);
   assign regs_o[REG_IRQ] = (BUS_W'(ie_q) << IRQ_IE_BIT) | (BUS_W'(pend_q) << IRQ_PEND_BIT);

   assign irq_o  = pend_q & ie_q;
   assign en_o   = en_q;
   assign rep_o  = rep_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned CNT_W  = 28,
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int unsigned CH_W = ADDR_W - 4;

   if (NUM_CH < 1 || NUM_CH > (1 << CH_W)) begin : g_bad_num
      $error("tmr_bank: NUM_CH does not fit the address space");
   end
   if (CNT_W < 2 || CNT_W > CTL_REP_BIT + 4) begin : g_bad_cnt
      $error("tmr_bank: CNT_W must be 2..28");
   end
   if (DIV_W < 2 || DIV_W > IRQ_PEND_BIT) begin : g_bad_div
      $error("tmr_bank: DIV_W must be 2..16");
   end

   logic [CH_W-1:0]                     ch_idx;
   tmr_reg_e                            r_idx;
   logic [NUM_CH-1:0][3:0][BUS_W-1:0]   words;
   logic [NUM_CH-1:0]                   ctl_wr_v, cnt_wr_v, irq_wr_v;
   logic [NUM_CH-1:0]                   en_v, rep_v, pend_v, hit_v;
   logic [NUM_CH-1:0][CNT_W-1:0]        cnt_v;
   logic [BUS_W-1:0]                    rd_word;

   assign ch_idx = addr[ADDR_W-1:4];
   assign r_idx  = tmr_reg_e'(addr[3:2]);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [3:0] sel;
      for (genvar k = 0; k < 4; k++) begin : g_sel
         assign sel[k] = wr_en && (ch_idx == CH_W'(g)) && (r_idx == tmr_reg_e'(k));
      end
      assign ctl_wr_v[g] = sel[REG_CTL];
      assign cnt_wr_v[g] = sel[REG_CNT];
      assign irq_wr_v[g] = sel[REG_IRQ];

      tmr_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .wr_sel(sel), .wdata(wdata),
         .regs_o(words[g]), .irq_o(irq[g]), .en_o(en_v[g]), .rep_o(rep_v[g]),
         .pend_o(pend_v[g]), .hit_o(hit_v[g]), .cnt_o(cnt_v[g])
      );
   end

   always_comb begin
      rd_word = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_idx == CH_W'(c)) rd_word = words[c][r_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
   end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned CNT_W  = 28,
   parameter int unsigned ADDR_W = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         rd_en,
   input logic [ADDR_W-1:0]            addr,
   input logic [31:0]                  wdata,
   input logic [31:0]                  rdata,
   input logic [NUM_CH-1:0]            ctl_wr_v,
   input logic [NUM_CH-1:0]            cnt_wr_v,
   input logic [NUM_CH-1:0]            irq_wr_v,
   input logic [NUM_CH-1:0]            en_v,
   input logic [NUM_CH-1:0]            rep_v,
   input logic [NUM_CH-1:0]            pend_v,
   input logic [NUM_CH-1:0]            hit_v,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v
);
   AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (int'(addr[ADDR_W-1:4]) >= NUM_CH)) |=> (rdata == '0)); // R11

   for (genvar i = 0; i < NUM_CH; i++) begin : g_a
      AST_ONESHOT_SELF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_v[i] && !rep_v[i] && !ctl_wr_v[i]) |=> !en_v[i]); // R5
      AST_REPEAT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_v[i] && rep_v[i] && !cnt_wr_v[i]) |=> (cnt_v[i] == '0)); // R6
      AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_wr_v[i] && wdata[16] && !hit_v[i]) |=> !pend_v[i]); // R7
      AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_v[i] && !cnt_wr_v[i]) |=> $stable(cnt_v[i])); // R9
   end
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .ctl_wr_v(ctl_wr_v), .cnt_wr_v(cnt_wr_v), .irq_wr_v(irq_wr_v),
   .en_v(en_v), .rep_v(rep_v), .pend_v(pend_v), .hit_v(hit_v), .cnt_v(cnt_v)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EN  = 32'h1000_0000;
   localparam logic [31:0] REP = 32'h0100_0000;
   localparam logic [31:0] IE  = 32'h0010_0000;
   localparam logic [31:0] PND = 32'h0001_0000;
   // {divider field, compare, expected clocks to expiry}
   localparam logic [47:0] VEC [6] = '{
      {16'd0, 16'd3, 16'd6},  {16'd1, 16'd4, 16'd8},  {16'd2, 16'd5, 16'd10},
      {16'd3, 16'd4, 16'd12}, {16'd5, 16'd2, 16'd10}, {16'd7, 16'd1, 16'd7}
   };

   logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic [5:0]  irq;
   int nchk = 0, nfail = 0;
   logic [31:0] r1, r2;
   int n;

   tmr_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .irq(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic wait_irq(input int b, output int cyc);
      cyc = 0;
      while (!irq[b] && cyc < 1000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 rdata", rdata, 32'h0);
      rd(8'h08, r1); chk("R1 ctrl", r1, 32'h0);
      rd(8'h40, r1); chk("R1 cmp", r1, 32'h0);

      // R4/R5 vector table on channel 0
      foreach (VEC[v]) begin
         wr(8'h08, 32'h0);
         wr(8'h0C, IE | PND);
         wr(8'h00, 32'(VEC[v][31:16]));
         wr(8'h04, 32'h0);
         wr(8'h08, EN | 32'(VEC[v][47:32]));
         wait_irq(0, n);
         chk("R4 expiry clocks", n, 32'(VEC[v][15:0]));
         rd(8'h08, r1); chk("R5 enable self-cleared", r1, 32'(VEC[v][47:32]));
         rd(8'h04, r1); chk("R5 count holds at compare", r1, 32'(VEC[v][31:16]));
      end

      // R7/R8 on channel 0 (pending, enabled)
      wr(8'h0C, IE);
      chk("R7 zero in pending bit keeps flag", 32'(irq[0]), 32'h1);
      wr(8'h0C, 32'h0);
      chk("R8 irq masked by enable", 32'(irq[0]), 32'h0);
      rd(8'h0C, r1); chk("R7 pending kept", r1, PND);
      wr(8'h0C, IE);
      chk("R8 irq with enable", 32'(irq[0]), 32'h1);
      wr(8'h0C, IE | PND);
      chk("R8 drop after clear", 32'(irq[0]), 32'h0);

      // R6 repeat on channel 1
      wr(8'h1C, IE | PND);
      wr(8'h10, 32'd3);
      wr(8'h14, 32'h0);
      wr(8'h18, EN | REP | 32'd2);
      wait_irq(1, n); chk("R6 first period", n, 32'd6);
      wr(8'h1C, IE | PND);
      chk("R6 cleared", 32'(irq[1]), 32'h0);
      wait_irq(1, n); chk("R6 second period", n, 32'd5);
      rd(8'h18, r1); chk("R6 still enabled", r1, EN | REP | 32'd2);

      // R9 halt
      wr(8'h18, 32'h0);
      rd(8'h14, r1);
      idle(10);
      rd(8'h14, r2); chk("R9 count frozen", r2, r1);
      rd(8'h18, r2); chk("R9 ctrl zero", r2, 32'h0);

      // R10 preset count on channel 2
      wr(8'h2C, IE | PND);
      wr(8'h20, 32'd7);
      wr(8'h24, 32'd5);
      rd(8'h24, r1); chk("R10 count readback", r1, 32'd5);
      wr(8'h28, EN | 32'd2);
      wait_irq(2, n); chk("R10 shortened period", n, 32'd4);

      // R2/R3 field widths and reserved bits on channel 3
      wr(8'h38, 32'hE1FF_0005);
      rd(8'h38, r1); chk("R3 ctrl reserved bits", r1, REP | 32'd5);
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h30, r1); chk("R2 compare 28 bits", r1, 32'h0FFF_FFFF);
      wr(8'h3C, 32'hFFFE_FFFF);
      rd(8'h3C, r1); chk("R3 irq reserved bits", r1, IE);
      chk("R3 no irq", 32'(irq[3]), 32'h0);

      // R11 unmapped slots
      wr(8'h60, 32'h1234);
      wr(8'h68, EN | 32'd2);
      wr(8'h70, 32'h55);
      rd(8'h60, r1); chk("R11 unmapped read", r1, 32'h0);
      rd(8'h6C, r1); chk("R11 unmapped irq read", r1, 32'h0);
      rd(8'h00, r1); chk("R11 ch0 compare intact", r1, 32'd1);
      rd(8'h10, r1); chk("R11 ch1 compare intact", r1, 32'd3);

      // R12 independent channels 4 and 5
      wr(8'h4C, IE | PND); wr(8'h5C, IE | PND);
      wr(8'h40, 32'd2);    wr(8'h50, 32'd5);
      wr(8'h44, 32'h0);    wr(8'h54, 32'h0);
      wr(8'h48, EN | 32'd2);
      wr(8'h58, EN | 32'd2);
      idle(3); chk("R12 ch4 fired alone", 32'(irq[5:4]), 32'h1);
      idle(6); chk("R12 ch5 not yet", 32'(irq[5:4]), 32'h1);
      idle(1); chk("R12 both fired", 32'(irq[5:4]), 32'h3);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule